// File: doc/BRIEF.md
# Stream-to-Descriptor Receive Frame Tracker

This block takes a packetised byte stream (TDATA, TVALID, TREADY, TLAST) and spreads its beats over a small queue of receive descriptors. Each descriptor holds a base address and a maximum byte length. Every accepted beat becomes one write on a simple memory-write port. The write address starts at the descriptor's base and advances by the beat width.

A descriptor closes in one of two ways. It closes when its byte length is filled, or it closes early on the beat that carries TLAST. When it closes, a completion entry goes into a status FIFO. The entry holds the bytes actually written and two flags: packet start and packet end. Software reads the entries one at a time with a pop strobe.

A packet longer than one descriptor continues into the next one. A new packet always begins in a fresh descriptor. The stream stalls by holding TREADY low in two cases: no descriptor is queued, or the completion FIFO is full.

Top module: `rxd_tracker`

## Requirements
- R1: Out of reset, sReady, cmplValid, wrValid, inPacket, statSof, statEof and errOverflow are all low. sReady is high exactly when at least one descriptor is queued and the completion FIFO (CMPL_DEPTH entries) has a free slot.
- R2: Each beat accepted in cycle N produces wrValid in cycle N+1. In that cycle wrData equals the beat's data and wrAddr equals the descriptor base plus DW/8 times the beat's index within its descriptor (the index counts from 0). wrValid is low in every cycle that does not follow an accepted beat.
- R3: Descriptor lengths are multiples of DW/8 and at least DW/8. A descriptor without TLAST closes on the beat that brings its byte count to its length, and its completion reports that length.
- R4: A TLAST beat closes its descriptor early, and the completion reports the bytes received so far. The next accepted beat goes to the next descriptor and is written at that descriptor's base address.
- R5: A completion's end flag (cmplEof) is 1 exactly when the beat that closed the descriptor carried TLAST.
- R6: A completion's start flag (cmplSof) is 1 exactly when the descriptor's first beat was the first accepted beat after reset or after a TLAST beat. A descriptor that continues a packet reports start flag 0.
- R7: Completions come out in the order their descriptors closed, starting the cycle after the closing beat. While cmplValid is high and cmplPop is low, the entry stays unchanged. A pop while the FIFO is empty has no effect.
- R8: A descriptor pushed while DESC_DEPTH descriptors are already queued is discarded. In that case errOverflow rises in the next cycle and stays high until reset.
- R9: inPacket is high after a non-TLAST beat is accepted and low after a TLAST beat is accepted. statSof and statEof show the start flag and the TLAST of the most recently accepted beat.
- R10: If the descriptor queue empties partway through a packet, sReady goes low and the offered beat is held, not lost. Streaming resumes once a descriptor is pushed. The continuing descriptor reports start flag 0.
- R11: While CMPL_DEPTH completions are waiting, sReady stays low even if descriptors are queued. It returns high after a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sData | input | DW | Stream beat data |
| sValid | input | 1 | Stream beat valid |
| sLast | input | 1 | Last beat of a packet |
| sReady | output | 1 | Beat accepted when high with sValid |
| descPush | input | 1 | Push one descriptor |
| descBase | input | AW | Descriptor base address |
| descLen | input | LW | Descriptor maximum length in bytes |
| cmplPop | input | 1 | Remove the head completion |
| cmplValid | output | 1 | A completion is available |
| cmplBytes | output | LW | Bytes written for the head completion |
| cmplSof | output | 1 | Head completion holds a packet start |
| cmplEof | output | 1 | Head completion holds a packet end |
| wrValid | output | 1 | Memory write strobe |
| wrAddr | output | AW | Memory write byte address |
| wrData | output | DW | Memory write data |
| inPacket | output | 1 | A packet is in progress |
| statSof | output | 1 | Start flag of the last accepted beat |
| statEof | output | 1 | End flag of the last accepted beat |
| errOverflow | output | 1 | Sticky: a descriptor push was dropped |

## Verification
The assertions assume that every descriptor length is a nonzero multiple of the beat width, because the completion-nonzero and closing checks depend on it. They also assume cmplPop is a plain strobe that may come while the FIFO is empty. The stimulus uses only lengths of 4, 8, 16 or 32 bytes with a 32-bit beat. It keeps sValid, sData and sLast steady while a beat is stalled. It deliberately issues pops on an empty FIFO and pushes into a full descriptor queue, so the drop and stall paths are exercised inside those assumptions.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // Strobes from control to datapath, one cycle wide.
  typedef struct packed {
    logic accept;   // beat taken this cycle
    logic close;    // the current descriptor ends with this beat
    logic sofBeat;  // this beat opens a packet
  } rxdStrobe_t;
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign rdata  = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tvalid,
  input  logic       tlast,
  input  logic       descAvail,
  input  logic       cmplSpace,
  input  logic       lenHit,
  input  logic       descPush,
  input  logic       descFull,
  output logic       tready,
  output rxdStrobe_t strobe,
  output logic       inPacket,
  output logic       statSof,
  output logic       statEof,
  output logic       errOverflow
);
  logic expectSof;
  logic accept;

  assign tready         = descAvail & cmplSpace;
  assign accept         = tvalid & tready;
  assign strobe.accept  = accept;
  assign strobe.close   = accept & (tlast | lenHit);
  assign strobe.sofBeat = expectSof;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectSof   <= 1'b1;
      inPacket    <= 1'b0;
      statSof     <= 1'b0;
      statEof     <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      if (accept) begin
        expectSof <= tlast;
        inPacket  <= ~tlast;
        statSof   <= expectSof;
        statEof   <= tlast;
      end
      if (descPush && descFull) errOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rxd_dp.sv
module rxd_dp
  import rxd_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxdStrobe_t    strobe,
  input  logic [DW-1:0] tdata,
  input  logic [AW-1:0] descBase,
  input  logic [LW-1:0] descLen,
  output logic          lenHit,
  output logic [LW-1:0] cmplBytes,
  output logic          cmplSof,
  output logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData
);
  localparam int          BPB  = DW / 8;
  localparam logic [LW:0] STEP = (LW+1)'(BPB);

  logic [LW-1:0] byteCnt;
  logic          descSofReg;
  logic          firstBeat;
  logic [LW:0]   sumWide;

  assign firstBeat = (byteCnt == '0);
  assign sumWide   = {1'b0, byteCnt} + STEP;
  assign lenHit    = (sumWide >= {1'b0, descLen});
  assign cmplBytes = sumWide[LW-1:0];
  assign cmplSof   = firstBeat ? strobe.sofBeat : descSofReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt    <= '0;
      descSofReg <= 1'b0;
      wrValid    <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
    end else begin
      wrValid <= strobe.accept;
      if (strobe.accept) begin
        wrAddr <= descBase + AW'(byteCnt);
        wrData <= tdata;
        if (strobe.close) begin
          byteCnt    <= '0;
          descSofReg <= 1'b0;
        end else begin
          byteCnt <= sumWide[LW-1:0];
          if (firstBeat) descSofReg <= strobe.sofBeat;
        end
      end
    end
  end
endmodule

// File: rtl/rxd_tracker.sv
module rxd_tracker
  import rxd_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int DESC_DEPTH = 4,
  parameter int CMPL_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] sData,
  input  logic          sValid,
  input  logic          sLast,
  output logic          sReady,
  input  logic          descPush,
  input  logic [AW-1:0] descBase,
  input  logic [LW-1:0] descLen,
  input  logic          cmplPop,
  output logic          cmplValid,
  output logic [LW-1:0] cmplBytes,
  output logic          cmplSof,
  output logic          cmplEof,
  output logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic          inPacket,
  output logic          statSof,
  output logic          statEof,
  output logic          errOverflow
);
  localparam int DESC_W = AW + LW;
  localparam int CMPL_W = LW + 2;

  rxdStrobe_t        strobe;
  logic [DESC_W-1:0] descHead;
  logic              descEmpty, descFull;
  logic [CMPL_W-1:0] cmplIn, cmplHead;
  logic              cmplEmpty, cmplFull;
  logic              lenHit, curSof;
  logic [LW-1:0]     curBytes;

  rxd_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_descQ (
    .clk(clk), .rstN(rstN),
    .push(descPush), .wdata({descBase, descLen}),
    .pop(strobe.close), .rdata(descHead),
    .empty(descEmpty), .full(descFull)
  );

  rxd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .tvalid(sValid), .tlast(sLast),
    .descAvail(~descEmpty), .cmplSpace(~cmplFull),
    .lenHit(lenHit), .descPush(descPush), .descFull(descFull),
    .tready(sReady), .strobe(strobe),
    .inPacket(inPacket), .statSof(statSof), .statEof(statEof),
    .errOverflow(errOverflow)
  );

  rxd_dp #(.DW(DW), .AW(AW), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tdata(sData),
    .descBase(descHead[DESC_W-1:LW]), .descLen(descHead[LW-1:0]),
    .lenHit(lenHit), .cmplBytes(curBytes), .cmplSof(curSof),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign cmplIn = {curBytes, curSof, sLast};

  rxd_fifo #(.W(CMPL_W), .DEPTH(CMPL_DEPTH)) u_cmplQ (
    .clk(clk), .rstN(rstN),
    .push(strobe.close), .wdata(cmplIn),
    .pop(cmplPop), .rdata(cmplHead),
    .empty(cmplEmpty), .full(cmplFull)
  );

  assign cmplValid = ~cmplEmpty;
  assign cmplBytes = cmplHead[CMPL_W-1:2];
  assign cmplSof   = cmplHead[1];
  assign cmplEof   = cmplHead[0];
endmodule

// File: rtl/rxd_tracker_chk.sv
module rxd_tracker_chk #(
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          sValid,
  input logic          sReady,
  input logic          sLast,
  input logic          descPush,
  input logic          descFull,
  input logic          descEmpty,
  input logic          cmplFull,
  input logic          cmplValid,
  input logic          cmplPop,
  input logic [LW-1:0] cmplBytes,
  input logic          cmplSof,
  input logic          cmplEof,
  input logic          wrValid,
  input logic          inPacket,
  input logic          errOverflow
);
  // R1, R10, R11: readiness needs a descriptor and completion room
  p_ready_guard_r1: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> (!descEmpty && !cmplFull));

  // R2: one write per accepted beat, one cycle later
  p_write_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sReady) |=> wrValid);

  p_no_stray_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(sValid && sReady) |=> !wrValid);

  // R3: every completion covers at least one beat
  p_cmpl_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> (cmplBytes != '0));

  // R7: the head completion holds until popped
  p_cmpl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && !cmplPop) |=>
      (cmplValid && $stable(cmplBytes) && $stable(cmplSof) && $stable(cmplEof)));

  // R8: a dropped push raises the error, and it sticks
  p_overflow_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (descPush && descFull) |=> errOverflow);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |=> errOverflow);

  // R9: a TLAST beat ends the packet
  p_tlast_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sReady && sLast) |=> !inPacket);
endmodule

bind rxd_tracker rxd_tracker_chk #(.LW(LW)) u_chk (
  .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady), .sLast(sLast),
  .descPush(descPush), .descFull(descFull), .descEmpty(descEmpty),
  .cmplFull(cmplFull), .cmplValid(cmplValid), .cmplPop(cmplPop),
  .cmplBytes(cmplBytes), .cmplSof(cmplSof), .cmplEof(cmplEof),
  .wrValid(wrValid), .inPacket(inPacket), .errOverflow(errOverflow)
);

// File: tb/rxd_tracker_bench.sv
`timescale 1ns/1ps
module rxd_tracker_bench;
  localparam int DW = 32, AW = 32, LW = 16, DD = 4, CD = 4, BPB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] sData = '0;
  logic          sValid = 1'b0, sLast = 1'b0;
  logic          sReady;
  logic          descPush = 1'b0;
  logic [AW-1:0] descBase = '0;
  logic [LW-1:0] descLen = '0;
  logic          cmplPop = 1'b0;
  logic          cmplValid, cmplSof, cmplEof;
  logic [LW-1:0] cmplBytes;
  logic          wrValid;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          inPacket, statSof, statEof, errOverflow;

  always #4 clk = ~clk;

  rxd_tracker #(.DW(DW), .AW(AW), .LW(LW), .DESC_DEPTH(DD), .CMPL_DEPTH(CD)) u_rxd_tracker (
    .clk(clk), .rstN(rstN), .sData(sData), .sValid(sValid), .sLast(sLast),
    .sReady(sReady), .descPush(descPush), .descBase(descBase), .descLen(descLen),
    .cmplPop(cmplPop), .cmplValid(cmplValid), .cmplBytes(cmplBytes),
    .cmplSof(cmplSof), .cmplEof(cmplEof), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .inPacket(inPacket), .statSof(statSof), .statEof(statEof),
    .errOverflow(errOverflow)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // Reference model state
  longint dBase[$], dLen[$], cBytes[$];
  bit     cSof[$], cEof[$];
  longint mCnt = 0;
  bit     mDescSof = 0, mExpectSof = 1, mInPkt = 0, mStatSof = 0, mStatEof = 0, mErr = 0;
  bit     mWrValid = 0;
  longint mWrAddr = 0, mWrData = 0;

  task automatic check(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic checkRegs();
    check("R2 wrValid", wrValid, mWrValid);
    if (mWrValid) begin
      check("R2 wrAddr", wrAddr, mWrAddr);
      check("R2 wrData", wrData, mWrData);
    end
    check("R9 inPacket", inPacket, mInPkt);
    check("R9 statSof", statSof, mStatSof);
    check("R9 statEof", statEof, mStatEof);
    check("R8 errOverflow", errOverflow, mErr);
  endtask

  // One clock: drive, compare the combinational outputs, advance the model, compare the registers.
  task automatic step(bit v, longint d, bit l, bit push, longint base, longint len, bit pop);
    bit     expReady, acc, close, first, beatSof;
    longint newCnt;
    sValid = v; sData = DW'(d); sLast = l;
    descPush = push; descBase = AW'(base); descLen = LW'(len); cmplPop = pop;
    #1;
    expReady = (dBase.size() > 0) && (cBytes.size() < CD);
    check("R1/R10/R11 sReady", sReady, expReady);
    check("R7 cmplValid", cmplValid, cBytes.size() > 0);
    if (cBytes.size() > 0) begin
      check("R3/R4 cmplBytes", cmplBytes, cBytes[0]);
      check("R6 cmplSof", cmplSof, cSof[0]);
      check("R5 cmplEof", cmplEof, cEof[0]);
    end
    acc = v && expReady;
    if (push && dBase.size() >= DD) mErr = 1;
    if (pop && cBytes.size() > 0) begin
      void'(cBytes.pop_front()); void'(cSof.pop_front()); void'(cEof.pop_front());
    end
    mWrValid = acc;
    if (acc) begin
      first   = (mCnt == 0);
      beatSof = first ? mExpectSof : mDescSof;
      newCnt  = mCnt + BPB;
      mWrAddr = (dBase[0] + mCnt) & 64'hFFFF_FFFF;
      mWrData = d & 64'hFFFF_FFFF;
      close   = l || (newCnt >= dLen[0]);
      mStatSof = mExpectSof;
      mStatEof = l;
      if (close) begin
        cBytes.push_back(newCnt); cSof.push_back(beatSof); cEof.push_back(l);
        void'(dBase.pop_front()); void'(dLen.pop_front());
        mCnt = 0; mDescSof = 0;
      end else begin
        if (first) mDescSof = mExpectSof;
        mCnt = newCnt;
      end
      mExpectSof = l;
      mInPkt = !l;
    end
    if (push && dBase.size() < DD && !(acc && dBase.size() == 0)) begin
      dBase.push_back(base); dLen.push_back(len);
    end
    @(posedge clk); #1;
    checkRegs();
  endtask

  int beat = 0;
  task automatic sendBeat(bit l, bit pop);
    step(1, 64'hA000_0000 + beat, l, 0, 0, 0, pop);
    if (sReady === 1'b0) ; // stalled beats are re-offered by the caller loop
  endtask

  // Offer a packet of n beats, re-offering each stalled beat, popping as asked
  task automatic sendPkt(int n, bit pop);
    for (int i = 0; i < n; i++) begin
      bit taken;
      taken = 0;
      while (!taken) begin
        taken = (dBase.size() > 0) && (cBytes.size() < CD);
        step(1, 64'hA000_0000 + beat, (i == n - 1), 0, 0, 0, pop);
        if (!taken && dBase.size() == 0)
          step(1, 64'hA000_0000 + beat, (i == n - 1), 1, 32'h9000 + 64 * beat, 16, pop);
      end
      beat++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 sReady reset", sReady, 0);
    check("R1 cmplValid reset", cmplValid, 0);
    checkRegs();
    rstN = 1'b1;
    @(posedge clk); #1;

    // R3 R5 R6: packet of 6 beats over two 16-byte descriptors
    step(0, 0, 0, 1, 32'h1000, 16, 0);
    step(0, 0, 0, 1, 32'h2000, 16, 0);
    sendPkt(6, 0);
    step(0, 0, 0, 0, 0, 0, 1);            // R7 pop first completion
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);            // R7 pop on empty has no effect

    // R4: early close on a 32-byte descriptor, next packet at next base
    step(0, 0, 0, 1, 32'h3000, 32, 0);
    step(0, 0, 0, 1, 32'h4000, 8, 0);
    sendPkt(2, 1);
    sendPkt(2, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    // R10: queue runs dry partway; sendPkt pushes late descriptors
    step(0, 0, 0, 1, 32'h5000, 8, 1);
    sendPkt(5, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    // R11: fill the completion FIFO without popping
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 32'h6000 + 256 * i, 4, 0);
    sendPkt(4, 0);
    step(0, 0, 0, 1, 32'h7000, 4, 0);
    step(1, 64'hBEEF, 1, 0, 0, 0, 0);      // R11 held low while full
    step(1, 64'hBEEF, 1, 0, 0, 0, 1);
    step(1, 64'hBEEF, 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 1);

    // R8: overflow the descriptor queue
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 32'h8000 + 64 * i, 16, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    sendPkt(3, 1);
    sendPkt(7, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule